// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of a 5-bit flash analog-to-digital converter. A bank of 31 comparators, each watching one rung of an evenly spaced reference ladder, delivers a thermometer code. Across the nominal 0.3 V to 1.3 V span, one step is roughly 31.3 mV. The block turns that code into a registered binary sample.

The conversion runs in two stages. The thermometer code is first mapped straight to a Gray code, and the result is registered. The registered Gray word is then converted to binary and captured in an output latch, so every output bit switches on the same clock edge, whatever the skew through the encoding logic. A sample-valid input marks the cycles that carry a real sample. The matching output strobe appears two clock edges later. When no sample arrives, the output holds its last code.

Top module: `flash_code_encoder`

## Requirements
- R1: For a well-formed thermometer input (bit k is high exactly when the input lies above reference level k+1, so the ones are packed from bit 0 upward), the output code equals the number of high input bits, as a 5-bit unsigned value.
- R2: An all-zeros thermometer input produces output code 0.
- R3: An all-ones thermometer input produces output code 31.
- R4: When one input bit of a well-formed code is inverted (a bubble), the Gray form of the output code (code XOR code>>1) differs from the Gray form of the correct code in at most one bit.
- R5: A sample presented with the valid input high at rising edge n appears on the code output, with the output strobe high, after rising edge n+1.
- R6: The output strobe is high for exactly one cycle per accepted sample. Back-to-back samples stream out one per cycle, in input order.
- R7: While no sample is being delivered, the output code holds the value of the most recent sample.
- R8: A synchronous active-high reset clears the output code to 0 and the strobe to low on the next rising edge, and it discards any sample still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 31 | Comparator thermometer code, bit k for level k+1 |
| therm_vld | input | 1 | High when therm_in carries a sample |
| code_out | output | 5 | Registered binary sample |
| code_vld | output | 1 | High when code_out carries a new sample |

## Verification
The assertions assume the comparator word is fully settled at each sampling edge. They assume the valid input is a clean synchronous level. Apart from the bubble tolerance, they assume the code is well formed. The stimulus drives every input on the falling clock edge, so both sides of each rising edge see stable values. It sweeps all 32 well-formed codes and every single-bit bubble on each of them. Bubbles are only checked against the one-bit Gray tolerance, never the exact count. Reset is asserted both at start-up and with samples in flight.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int CODE_W_DEF = 5;

  function automatic int unsigned therm_width(input int unsigned code_w);
    return (1 << code_w) - 1;
  endfunction
endpackage

// File: rtl/fce_therm2gray.sv
module fce_therm2gray #(
  parameter int CODE_W  = 5,
  parameter int THERM_W = (1 << CODE_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [THERM_W-1:0] therm_i,
  input  logic               vld_i,
  output logic [CODE_W-1:0]  gray_q,
  output logic               vld_q
);
  localparam int GROUPS = THERM_W / 4 + 1;

  logic [CODE_W-1:0] gray_d;

  // Gray bit i is high for counts in [2^i(4m+1), 2^i(4m+3)); each term is
  // one window edge pair of the thermometer, so every input bit feeds one term.
  generate
    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_bit
      always_comb begin
        gray_d[gi] = 1'b0;
        for (int m = 0; m < GROUPS; m++) begin
          int lo;
          int hi;
          lo = (4 * m + 1) << gi;
          hi = (4 * m + 3) << gi;
          if (lo <= THERM_W) begin
            if (hi <= THERM_W)
              gray_d[gi] = gray_d[gi] | (therm_i[lo-1] & ~therm_i[hi-1]);
            else
              gray_d[gi] = gray_d[gi] | therm_i[lo-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gray_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) gray_q <= gray_d;
    end
  end

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    (vld_i && therm_i == '0) |=> (gray_q == '0)); // R2

  AST_FULL_CODE: assert property (@(posedge clk) disable iff (rst)
    (vld_i && (&therm_i)) |=> (gray_q == CODE_W'(1 << (CODE_W - 1)))); // R3
endmodule

// File: rtl/fce_gray2bin.sv
module fce_gray2bin #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] gray_i,
  input  logic              vld_i,
  output logic [CODE_W-1:0] bin_q,
  output logic              vld_q
);
  logic [CODE_W-1:0] bin_d;

  assign bin_d[CODE_W-1] = gray_i[CODE_W-1];
  generate
    for (genvar gi = CODE_W - 2; gi >= 0; gi--) begin : g_fold
      assign bin_d[gi] = bin_d[gi+1] ^ gray_i[gi];
    end
  endgenerate

  // Output latch: all bits leave on the same edge regardless of fold depth.
  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) bin_q <= bin_d;
    end
  end

  AST_BIN_MATCH: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> ((bin_q ^ (bin_q >> 1)) == $past(gray_i))); // R1

  AST_BIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(bin_q)); // R7
endmodule

// File: rtl/flash_code_encoder.sv
module flash_code_encoder #(
  parameter int CODE_W  = fce_pkg::CODE_W_DEF,
  parameter int THERM_W = (1 << CODE_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [THERM_W-1:0] therm_in,
  input  logic               therm_vld,
  output logic [CODE_W-1:0]  code_out,
  output logic               code_vld
);
  logic [CODE_W-1:0] gray_mid;
  logic              vld_mid;

  fce_therm2gray #(.CODE_W(CODE_W), .THERM_W(THERM_W)) u_enc (
    .clk(clk), .rst(rst), .therm_i(therm_in), .vld_i(therm_vld),
    .gray_q(gray_mid), .vld_q(vld_mid)
  );

  fce_gray2bin #(.CODE_W(CODE_W)) u_conv (
    .clk(clk), .rst(rst), .gray_i(gray_mid), .vld_i(vld_mid),
    .bin_q(code_out), .vld_q(code_vld)
  );

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (code_vld == $past(therm_vld, 2))); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd2) |-> !code_vld); // R6

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (code_out == '0 && !code_vld)); // R8
endmodule

// File: tb/flash_code_encoder_bench.sv
module flash_code_encoder_bench;
  localparam int CW = 5;
  localparam int TW = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] therm_in = '0;
  logic therm_vld = 1'b0;
  logic [CW-1:0] code_out;
  logic code_vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the two pipeline stages
  bit m1_v = 0, mo_v = 0, m1_tol = 0, mo_tol = 0;
  int m1_val = 0, mo_val = 0;
  string m1_tag = "R1", mo_tag = "R1";

  always #2 clk = ~clk;

  flash_code_encoder u_flash_code_encoder (
    .clk(clk), .rst(rst), .therm_in(therm_in), .therm_vld(therm_vld),
    .code_out(code_out), .code_vld(code_vld)
  );

  function automatic logic [TW-1:0] therm_of(input int n);
    logic [TW-1:0] t;
    for (int k = 0; k < TW; k++) t[k] = (k < n);
    return t;
  endfunction

  function automatic int gray_dist(input int a, input int b);
    int ga, gb, d;
    ga = a ^ (a >> 1);
    gb = b ^ (b >> 1);
    d = 0;
    for (int k = 0; k < CW; k++) if (((ga ^ gb) >> k) & 1) d++;
    return d;
  endfunction

  task automatic check_now();
    n_run++;
    if (code_vld !== mo_v) begin
      n_fail++;
      $display("FAIL %s/R5/R6 strobe: actual %0b expected %0b", mo_tag, code_vld, mo_v);
    end
    n_run++;
    if (mo_tol) begin
      if (gray_dist(int'(code_out), mo_val) > 1) begin
        n_fail++;
        $display("FAIL R4 bubble: actual %0d expected within one Gray bit of %0d",
                 code_out, mo_val);
      end
    end else if (int'(code_out) !== mo_val) begin
      n_fail++;
      $display("FAIL %s code: actual %0d expected %0d", mo_tag, code_out, mo_val);
    end
  endtask

  task automatic step(input logic [TW-1:0] t, input bit v, input int ev,
                      input bit tol, input string tag);
    @(negedge clk);
    check_now();
    therm_in = t;
    therm_vld = v;
    @(posedge clk);
    if (m1_v) begin
      mo_val = m1_val; mo_tol = m1_tol; mo_tag = m1_tag;
    end else if (!mo_v) begin
      mo_tag = "R7";
    end
    mo_v = m1_v;
    if (!m1_v && mo_v == 0) mo_tag = "R7";
    m1_v = v;
    if (v) begin
      m1_val = ev; m1_tol = tol; m1_tag = tag;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    therm_vld = 1'b1;
    therm_in = '1;
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (code_out !== '0 || code_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: actual code %0d vld %0b expected 0 0", code_out, code_vld);
    end
    therm_vld = 1'b0;
    therm_in = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m1_v = 0; mo_v = 0; m1_val = 0; mo_val = 0;
    m1_tol = 0; mo_tol = 0; m1_tag = "R8"; mo_tag = "R8";
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    do_reset();
    // R2 / R3 corners
    step('0, 1, 0, 0, "R2");
    step('1, 1, TW, 0, "R3");
    step('0, 0, 0, 0, "R7");
    step('0, 0, 0, 0, "R7");
    step('0, 0, 0, 0, "R7");
    // R5 single sample latency, then idle
    step(therm_of(9), 1, 9, 0, "R5");
    for (int i = 0; i < 4; i++) step(therm_of(20), 0, 0, 0, "R7");
    // R1/R6 back-to-back sweep up and down
    for (int n = 0; n <= TW; n++) step(therm_of(n), 1, n, 0, "R1");
    for (int n = TW; n >= 0; n--) step(therm_of(n), 1, n, 0, "R6");
    // R7 gapped samples with junk on the idle input
    for (int n = 0; n <= TW; n += 3) begin
      step(therm_of(n), 1, n, 0, "R7");
      step(therm_of(TW - n), 0, 0, 0, "R7");
      step('1, 0, 0, 0, "R7");
    end
    // R4 every single-bit bubble on every well-formed code
    for (int n = 0; n <= TW; n++) begin
      for (int k = 0; k < TW; k++) begin
        logic [TW-1:0] t;
        t = therm_of(n);
        t[k] = ~t[k];
        step(t, 1, n, 1, "R4");
      end
    end
    // R8 reset with samples in flight
    step(therm_of(17), 1, 17, 0, "R1");
    step(therm_of(5), 1, 5, 0, "R1");
    do_reset();
    step(therm_of(3), 0, 0, 0, "R8");
    step(therm_of(3), 0, 0, 0, "R8");
    step(therm_of(12), 1, 12, 0, "R1");
    for (int i = 0; i < 3; i++) step('0, 0, 0, 0, "R7");
    finish_run();
  end
endmodule